// File: doc/BRIEF.md
# Multi-Sector Erase Queue with Acceptance Window

This block gathers the sectors of a multi-sector erase before the erase starts. A command decoder upstream recognises the full six-cycle sector erase sequence, whose final write carries both the sector address and the erase command. For each such sequence, and for each extra address-plus-command write that follows, the decoder sends a one-cycle accept pulse with a sector index. The first accepted sector opens an acceptance window. While the window is open, further sectors can be marked in any order. Each new sector restarts the window, which lasts a parameterised number of timer ticks.

When the window runs out, the erase begins on every marked sector. Per-sector completion pulses clear the marked bits one by one. When the last bit clears, the block goes back to idle, which matches the bank returning to read mode. While an erase is pending or running, the block drives three status bits: a polling bit, a toggle bit that flips on every status read, and a second toggle bit that flips only for reads aimed at a marked sector. A hardware reset drops the whole queue at once.

Top module: `seq_erase_queue`

## Requirements
- R1: After reset, `sect_mask` is all zeros, `busy` is 0, `dq7_stat` is 1, and `dq6_tog` and `dq2_tog` are both 0.
- R2: When `add_valid` is high while `busy` is low, the next clock edge sets `sect_mask` bit `add_sect` and raises `busy`, which opens the acceptance window.
- R3: While the window is open, each `add_valid` sets bit `add_sect` of `sect_mask`. Sectors can arrive in any order, and bits set earlier are kept.
- R4: Each accepted sector reloads the window to TMO_TICKS ticks. The erase phase starts on the edge that carries the TMO_TICKS-th `tick` with no accept in between. If `tick` and `add_valid` arrive in the same cycle, the accept wins and the window restarts.
- R5: During the erase phase, `add_valid` is ignored and `sect_mask` gains no bits.
- R6: During the erase phase, a high bit `sect_done[i]` clears `sect_mask[i]`. `sect_done` has no effect while idle or while the window is open. On the edge where the last marked bit clears, `busy` falls.
- R7: `dq7_stat` is 0 while `busy` is high and 1 otherwise.
- R8: `dq6_tog` inverts on each edge where `rd_stb` is high while `busy` is high. Otherwise it holds its value.
- R9: `dq2_tog` inverts on an edge where `rd_stb` is high, `busy` is high and `sect_mask[rd_sect]` is 1. Otherwise it holds its value.
- R10: Driving `rst_n` low clears `sect_mask` and `busy` at once, without waiting for a clock edge, and aborts any pending or running erase. Release from reset takes effect on the third clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| add_valid | input | 1 | One-cycle accept of a sector erase write |
| add_sect | input | SW | Sector index of the accepted write |
| tick | input | 1 | Timer tick used to time the acceptance window |
| sect_done | input | NUM_SECT | Per-sector erase completion pulses |
| rd_stb | input | 1 | Status read strobe |
| rd_sect | input | SW | Sector addressed by the status read |
| sect_mask | output | NUM_SECT | Sectors marked for erase |
| busy | output | 1 | High while the window is open or the erase is running |
| dq7_stat | output | 1 | Polling bit: 0 while busy |
| dq6_tog | output | 1 | Toggle bit that flips on every read while busy |
| dq2_tog | output | 1 | Toggle bit that flips on reads of marked sectors while busy |

## Verification
Two events can land in the same cycle: the last timer tick of the window and a new sector accept. The bench drives both together, as well as a tick alone on the final count. The first case must restart the window. The second must start the erase. A behavioural reference model makes both calls, and the outputs are compared with it on every clock. A randomised phase also places status reads in the same cycles as completion pulses and accepts, so the toggle bits are judged against the mask as it stood before that edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_OPEN  = 2'd1,
    SQ_ERASE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sq_rst_sync.sv
module sq_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_s = s2_q;
endmodule

// File: rtl/sq_window_timer.sv
module sq_window_timer #(
  parameter int TMO_TICKS = 8,
  localparam int CW = $clog2(TMO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TMO_TICKS);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // a reload in the same cycle overrides the last tick
  assign expire = run & tick & ~load & (cnt_q == ONE);
endmodule

// File: rtl/sq_mask_reg.sv
module sq_mask_reg #(
  parameter int NUM_SECT = 16,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [SW-1:0]       set_idx,
  input  logic                clr_en,
  input  logic [NUM_SECT-1:0] clr_vec,
  output logic [NUM_SECT-1:0] mask_q,
  output logic                nxt_empty
);
  logic [NUM_SECT-1:0] mask_d;
  logic                mask_en;

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_bit
    always_comb begin
      mask_d[gi] = (mask_q[gi] | (set_en && (set_idx == SW'(gi))))
                   & ~(clr_en & clr_vec[gi]);
    end
  end

  assign mask_en   = set_en | clr_en;
  assign nxt_empty = (mask_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/sq_status.sv
module sq_status #(
  parameter int NUM_SECT = 16,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                rd_stb,
  input  logic [SW-1:0]       rd_idx,
  input  logic [NUM_SECT-1:0] mask,
  output logic                dq6_q,
  output logic                dq2_q
);
  logic hit;
  logic t6_en, t2_en;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (rd_idx == SW'(i)) hit = mask[i];
    end
  end

  assign t6_en = rd_stb & busy;
  assign t2_en = rd_stb & busy & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dq6_q <= 1'b0;
    else if (t6_en) dq6_q <= ~dq6_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dq2_q <= 1'b0;
    else if (t2_en) dq2_q <= ~dq2_q;
  end
endmodule

// File: rtl/seq_erase_queue.sv
module seq_erase_queue #(
  parameter int NUM_SECT  = 16,
  parameter int TMO_TICKS = 8,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_valid,
  input  logic [SW-1:0]       add_sect,
  input  logic                tick,
  input  logic [NUM_SECT-1:0] sect_done,
  input  logic                rd_stb,
  input  logic [SW-1:0]       rd_sect,
  output logic [NUM_SECT-1:0] sect_mask,
  output logic                busy,
  output logic                dq7_stat,
  output logic                dq6_tog,
  output logic                dq2_tog
);
  import sq_pkg::*;

  logic      rst_n_s;
  sq_state_e st_q, st_d;
  logic      accept, expire, nxt_empty, in_erase;

  sq_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign in_erase = (st_q == SQ_ERASE);
  assign accept   = add_valid & ~in_erase;

  sq_window_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (accept),
    .run    (st_q == SQ_OPEN),
    .tick   (tick),
    .expire (expire)
  );

  sq_mask_reg #(.NUM_SECT(NUM_SECT)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_en    (accept),
    .set_idx   (add_sect),
    .clr_en    (in_erase),
    .clr_vec   (sect_done),
    .mask_q    (sect_mask),
    .nxt_empty (nxt_empty)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:  if (add_valid) st_d = SQ_OPEN;
      SQ_OPEN:  if (expire)    st_d = SQ_ERASE;
      SQ_ERASE: if (nxt_empty) st_d = SQ_IDLE;
      default:                 st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= SQ_IDLE;
    else          st_q <= st_d;
  end

  assign busy     = (st_q != SQ_IDLE);
  assign dq7_stat = ~busy;

  sq_status #(.NUM_SECT(NUM_SECT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .busy   (busy),
    .rd_stb (rd_stb),
    .rd_idx (rd_sect),
    .mask   (sect_mask),
    .dq6_q  (dq6_tog),
    .dq2_q  (dq2_tog)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int NUM_SECT = 16,
  parameter int SW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                add_valid,
  input logic [SW-1:0]       add_sect,
  input logic                rd_stb,
  input logic [NUM_SECT-1:0] sect_mask,
  input logic                busy,
  input logic                erasing,
  input logic                dq6_tog,
  input logic                dq2_tog
);
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && !busy) |=> (busy && sect_mask[$past(add_sect)]));

  a_r3_collect: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && busy && !erasing) |=> sect_mask[$past(add_sect)]);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |=> ((sect_mask & ~$past(sect_mask)) == '0));

  a_r6_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sect_mask == '0));

  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> (dq6_tog != $past(dq6_tog)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && busy) |=> $stable(dq6_tog));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && busy) |=> $stable(dq2_tog));
endmodule

bind seq_erase_queue sq_checker #(.NUM_SECT(NUM_SECT), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .add_valid (add_valid),
  .add_sect  (add_sect),
  .rd_stb    (rd_stb),
  .sect_mask (sect_mask),
  .busy      (busy),
  .erasing   (st_q == sq_pkg::SQ_ERASE),
  .dq6_tog   (dq6_tog),
  .dq2_tog   (dq2_tog)
);

// File: tb/test_seq_erase_queue.sv
module test_seq_erase_queue;
  localparam int NS  = 16;
  localparam int TMO = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          add_valid = 1'b0;
  logic [3:0]    add_sect = '0;
  logic          tick = 1'b0;
  logic [NS-1:0] sect_done = '0;
  logic          rd_stb = 1'b0;
  logic [3:0]    rd_sect = '0;
  logic [NS-1:0] sect_mask;
  logic          busy, dq7_stat, dq6_tog, dq2_tog;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  seq_erase_queue #(.NUM_SECT(NS), .TMO_TICKS(TMO)) i_seq_erase_queue (
    .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .add_sect(add_sect),
    .tick(tick), .sect_done(sect_done), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .sect_mask(sect_mask), .busy(busy), .dq7_stat(dq7_stat),
    .dq6_tog(dq6_tog), .dq2_tog(dq2_tog)
  );

  // behavioural reference model: 0 idle, 1 window, 2 erasing
  int            m_state = 0;
  int            m_cnt = 0;
  int            m_rel = 0;
  bit [NS-1:0]   m_mask = '0;
  bit            m_d6 = 1'b0;
  bit            m_d2 = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_rel = 0; m_mask = '0; m_d6 = 0; m_d2 = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (rd_stb && m_state != 0) begin
        m_d6 = ~m_d6;
        if (m_mask[rd_sect]) m_d2 = ~m_d2;
      end
      case (m_state)
        0: if (add_valid) begin
             m_mask[add_sect] = 1'b1; m_cnt = TMO; m_state = 1;
           end
        1: if (add_valid) begin
             m_mask[add_sect] = 1'b1; m_cnt = TMO;
           end else if (tick) begin
             m_cnt--;
             if (m_cnt == 0) m_state = 2;
           end
        default: begin
          m_mask = m_mask & ~sect_done;
          if (m_mask == '0) m_state = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk(sect_mask == m_mask, cur_req, "model mask", 32'(sect_mask), 32'(m_mask));
    chk({busy, dq7_stat, dq6_tog, dq2_tog} ==
        {m_state != 0, m_state == 0, m_d6, m_d2},
        cur_req, "model status", 32'({busy, dq7_stat, dq6_tog, dq2_tog}),
        32'({m_state != 0, m_state == 0, m_d6, m_d2}));
  endtask

  task automatic cyc(input bit av, input int as, input bit tk,
                     input logic [NS-1:0] dn, input bit rd, input int rs);
    add_valid = av; add_sect = 4'(as); tick = tk;
    sect_done = dn; rd_stb = rd; rd_sect = 4'(rs);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    bit d6, d2;
    @(negedge clk);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    chk(sect_mask == '0 && !busy && dq7_stat && !dq6_tog && !dq2_tog, "R1",
        "reset state", 32'({sect_mask, busy, dq7_stat, dq6_tog, dq2_tog}), 32'h4);

    cur_req = "R2";
    cyc(1, 3, 0, '0, 0, 0);
    chk(busy && sect_mask == 16'h0008, "R2", "open window", 32'({busy, sect_mask}), 32'h10008);
    chk(!dq7_stat, "R7", "dq7 low while busy", 32'(dq7_stat), 0);

    cur_req = "R4";
    for (int i = 0; i < TMO - 2; i++) cyc(0, 0, 1, '0, 0, 0);
    cyc(1, 9, 1, '0, 0, 0);               // tick and accept together: restart
    for (int i = 0; i < TMO - 1; i++) cyc(0, 0, 1, '0, 0, 0);
    chk(busy, "R4", "window still open", 32'(busy), 1);
    cur_req = "R3";
    cyc(1, 0, 0, '0, 0, 0);               // lower index after higher ones
    chk(sect_mask == 16'h0209, "R3", "any-order add", 32'(sect_mask), 32'h0209);
    for (int i = 0; i < TMO - 1; i++) cyc(0, 0, 1, '0, 0, 0);
    cur_req = "R6";
    cyc(0, 0, 0, 16'h0008, 0, 0);         // done while window open
    chk(sect_mask == 16'h0209, "R6", "done ignored in window", 32'(sect_mask), 32'h0209);
    cur_req = "R4";
    cyc(0, 0, 1, '0, 0, 0);               // final tick -> erase
    cur_req = "R5";
    cyc(1, 12, 0, '0, 0, 0);
    chk(sect_mask == 16'h0209 && busy, "R5", "add ignored in erase",
        32'(sect_mask), 32'h0209);

    cur_req = "R8";
    d6 = dq6_tog; d2 = dq2_tog;
    cyc(0, 0, 0, '0, 1, 3);
    chk(dq6_tog == ~d6, "R8", "dq6 flips on read", 32'(dq6_tog), 32'(~d6));
    chk(dq2_tog == ~d2, "R9", "dq2 flips on marked read", 32'(dq2_tog), 32'(~d2));
    cur_req = "R9";
    d6 = dq6_tog; d2 = dq2_tog;
    cyc(0, 0, 0, '0, 1, 5);
    chk(dq6_tog == ~d6, "R8", "dq6 flips again", 32'(dq6_tog), 32'(~d6));
    chk(dq2_tog == d2, "R9", "dq2 holds on unmarked read", 32'(dq2_tog), 32'(d2));

    cur_req = "R6";
    cyc(0, 0, 0, 16'h0028, 0, 0);
    chk(sect_mask == 16'h0201 && busy, "R6", "partial done", 32'(sect_mask), 32'h0201);
    cyc(0, 0, 0, 16'h0201, 0, 0);
    chk(sect_mask == '0 && !busy && dq7_stat, "R6", "last done ends erase",
        32'({busy, sect_mask}), 0);
    cur_req = "R8";
    d6 = dq6_tog;
    cyc(0, 0, 0, '0, 1, 0);
    chk(dq6_tog == d6, "R8", "dq6 holds while idle", 32'(dq6_tog), 32'(d6));

    cur_req = "R10";
    cyc(1, 7, 0, '0, 0, 0);
    for (int i = 0; i < TMO; i++) cyc(0, 0, 1, '0, 0, 0);
    #2 rst_n = 1'b0;
    #1;
    chk(sect_mask == '0 && !busy, "R10", "async abort", 32'({busy, sect_mask}), 0);
    @(negedge clk);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    chk(!busy && dq7_stat, "R10", "idle after abort", 32'(busy), 0);

    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) == 0, int'($urandom % NS), ($urandom % 3) == 0,
          (($urandom % 4) == 0) ? NS'(1) << ($urandom % NS) : '0,
          ($urandom % 2) == 0, int'($urandom % NS));
    end
    idle(2);
    summary();
  end
endmodule